// File: doc/BRIEF.md
# Dual-Rail Phase-Frequency Detector with Lock Indicator

This block compares two pulse trains in a synthesizer loop: a reference event stream from the reference divider and a feedback event stream from the feedback divider. Both arrive as single-cycle pulses that are synchronous to `clk`. Each event stream sets its own state flag. When both flags are set, they stay set for a fixed minimum on-time and then clear together. This short common pulse is what keeps the transfer free of a dead zone when the two streams are in step.

The flags drive two active-low error rails, one per input. They also drive a single-ended error output with an output enable, meant for a three-state pad: it drives high while the reference leads, drives low while the feedback leads, and is released when neither or both flags are set. A lock indicator stays high while the loop is in step. It drops low once one flag has been set alone for longer than the minimum on-time. The charge pump, the loop filter and the pads lie outside the block.

Top module: `pfd_lockdet`

## Requirements
- R1: While reset is held, and after it is released with no events, both rails are high, the single-ended enable is low, the single-ended drive is low and the lock indicator is high.
- R2: A reference event pulls `phi_ref_n` low from the next cycle while `phi_fb_n` stays high. `phi_ref_n` remains low until the coincidence sequence ends.
- R3: A feedback event pulls `phi_fb_n` low from the next cycle while `phi_ref_n` stays high. `phi_fb_n` remains low until the coincidence sequence ends.
- R4: Once both flags are set, both rails are low for exactly MIN_ON cycles (default 2). After that, both rails return high in the same cycle.
- R5: Reference and feedback events in the same cycle, from idle, produce only the MIN_ON-cycle common low pulse on both rails. The single-ended enable stays low throughout.
- R6: `se_oe` is high exactly in the cycles where one rail is low and the other is high. During those cycles, `se_drive` is 1 when the reference rail is the low one and 0 when the feedback rail is the low one. `se_drive` is 0 whenever `se_oe` is 0.
- R7: `lock_ok` is low in a cycle exactly when one flag has been set alone for more than MIN_ON consecutive cycles, counting that cycle. Otherwise it is high.
- R8: A further event on an input whose flag is already set changes no output. This holds everywhere except in the final cycle of the coincidence pulse, where the event re-arms the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| ref_evt | input | 1 | Single-cycle reference event |
| fb_evt | input | 1 | Single-cycle feedback event |
| phi_ref_n | output | 1 | Active-low reference error rail |
| phi_fb_n | output | 1 | Active-low feedback error rail |
| se_drive | output | 1 | Value driven by the single-ended error output |
| se_oe | output | 1 | Output enable of the single-ended error output |
| lock_ok | output | 1 | High while in lock; low while out of lock |

## Verification
The hardest situation to reach from the ports is the boundary of the lock indicator. One flag must be held alone for exactly MIN_ON, then MIN_ON+1, cycles, and the change must be seen in the right cycle. The bench sweeps the gap between the leading and the lagging event from 0 to 8 cycles, with each input taking the lead in turn, and compares every output in every cycle against an arithmetic model of the gap. A further pass injects repeated leading events inside the solo window. This shows that a repeat neither extends nor restarts the window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic ref_set;
    logic fb_set;
  } pfd_flags_t;

  function automatic logic flags_solo(input pfd_flags_t f);
    return f.ref_set ^ f.fb_set;
  endfunction

  function automatic logic flags_both(input pfd_flags_t f);
    return f.ref_set & f.fb_set;
  endfunction

endpackage

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
#(
  parameter int MIN_ON = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_evt,
  input  logic       fb_evt,
  output pfd_flags_t flags
);
  localparam int CW = (MIN_ON < 2) ? 1 : $clog2(MIN_ON);

  pfd_flags_t    flags_q, flags_nx;
  logic [CW-1:0] ov_q, ov_nx;
  logic          clr;

  // both flags have been set together for MIN_ON cycles
  always_comb begin
    clr              = flags_both(flags_q) && (ov_q == CW'(MIN_ON - 1));
    flags_nx.ref_set = (flags_q.ref_set & ~clr) | ref_evt;
    flags_nx.fb_set  = (flags_q.fb_set  & ~clr) | fb_evt;
    if (flags_both(flags_q) && !clr) ov_nx = ov_q + 1'b1;
    else                             ov_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ov_q    <= '0;
    end else begin
      flags_q <= flags_nx;
      ov_q    <= ov_nx;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
  import pfd_pkg::*;
#(
  parameter int MIN_ON = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pfd_flags_t flags,
  output logic       lock_ok
);
  localparam int SW = $clog2(MIN_ON + 1);

  logic [SW-1:0] solo_q, solo_nx;
  logic          solo;

  // solo_q counts preceding consecutive solo cycles, saturating at MIN_ON
  always_comb begin
    solo = flags_solo(flags);
    if (!solo)                          solo_nx = '0;
    else if (solo_q == SW'(MIN_ON))     solo_nx = solo_q;
    else                                solo_nx = solo_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) solo_q <= '0;
    else        solo_q <= solo_nx;
  end

  assign lock_ok = ~(solo && (solo_q == SW'(MIN_ON)));
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  pfd_flags_t flags,
  output logic       phi_ref_n,
  output logic       phi_fb_n,
  output logic       se_drive,
  output logic       se_oe
);
  always_comb begin
    phi_ref_n = ~flags.ref_set;
    phi_fb_n  = ~flags.fb_set;
    se_oe     = flags_solo(flags);
    se_drive  = flags.ref_set & ~flags.fb_set;
  end
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
  import pfd_pkg::*;
#(
  parameter int MIN_ON = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic phi_ref_n,
  output logic phi_fb_n,
  output logic se_drive,
  output logic se_oe,
  output logic lock_ok
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pfd_flags_t flags;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pfd_flag_core #(.MIN_ON(MIN_ON)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ref_evt (ref_evt),
    .fb_evt  (fb_evt),
    .flags   (flags)
  );

  pfd_lock_mon #(.MIN_ON(MIN_ON)) u_lock (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flags   (flags),
    .lock_ok (lock_ok)
  );

  pfd_out_stage u_out (
    .flags     (flags),
    .phi_ref_n (phi_ref_n),
    .phi_fb_n  (phi_fb_n),
    .se_drive  (se_drive),
    .se_oe     (se_oe)
  );
endmodule

// File: rtl/pfd_lockdet_chk.sv
module pfd_lockdet_chk #(
  parameter int MIN_ON = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ref_evt,
  input logic fb_evt,
  input logic phi_ref_n,
  input logic phi_fb_n,
  input logic se_drive,
  input logic se_oe,
  input logic lock_ok
);
  int unsigned both_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      both_run <= 0;
    else if (!phi_ref_n && !phi_fb_n) both_run <= both_run + 1;
    else                             both_run <= 0;
  end

  AST_REF_EVT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt && !fb_evt && phi_ref_n && phi_fb_n) |=> (!phi_ref_n && phi_fb_n)); // R2
  AST_FB_EVT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_evt && !ref_evt && phi_ref_n && phi_fb_n) |=> (!phi_fb_n && phi_ref_n)); // R3
  AST_COINC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    both_run <= MIN_ON); // R4
  AST_SIMUL_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt && fb_evt && phi_ref_n && phi_fb_n) |=> (!se_oe && !phi_ref_n && !phi_fb_n)); // R5
  AST_OE_DRIVE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    se_oe |-> (se_drive == !phi_ref_n)); // R6
  AST_UNLOCK_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |-> (se_oe && $stable(phi_ref_n) && $stable(phi_fb_n))); // R7
endmodule

bind pfd_lockdet pfd_lockdet_chk #(.MIN_ON(MIN_ON)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_evt   (ref_evt),
  .fb_evt    (fb_evt),
  .phi_ref_n (phi_ref_n),
  .phi_fb_n  (phi_fb_n),
  .se_drive  (se_drive),
  .se_oe     (se_oe),
  .lock_ok   (lock_ok)
);

// File: tb/test_pfd_lockdet.sv
module test_pfd_lockdet;
  localparam int MIN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_evt = 1'b0;
  logic fb_evt = 1'b0;
  logic phi_ref_n, phi_fb_n, se_drive, se_oe, lock_ok;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  pfd_lockdet #(.MIN_ON(MIN)) i_pfd_lockdet (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .phi_ref_n(phi_ref_n), .phi_fb_n(phi_fb_n),
    .se_drive(se_drive), .se_oe(se_oe), .lock_ok(lock_ok)
  );

  // vector order: phi_ref_n, phi_fb_n, se_drive, se_oe, lock_ok
  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {phi_ref_n, phi_fb_n, se_drive, se_oe, lock_ok};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // leader event, lagger after gap d; dup adds leader repeats (R8)
  task automatic run_case(input bit ref_lead, input int d, input bit dup);
    string tag;
    @(negedge clk);
    if (d == 0) begin ref_evt = 1'b1; fb_evt = 1'b1; end
    else if (ref_lead) ref_evt = 1'b1;
    else fb_evt = 1'b1;
    for (int k = 1; k <= d + MIN + 2; k++) begin
      bit solo, both, rset, fset;
      @(negedge clk);
      ref_evt = 1'b0; fb_evt = 1'b0;
      solo = (k <= d);
      both = (k > d) && (k <= d + MIN);
      rset = both || (solo && ref_lead);
      fset = both || (solo && !ref_lead);
      if (dup)         tag = "R8";
      else if (d == 0) tag = "R5";
      else if (solo && k > MIN) tag = "R7";
      else if (both)   tag = "R4";
      else if (solo)   tag = ref_lead ? "R2" : "R3";
      else             tag = "R6";
      check(tag, {!rset, !fset, solo && ref_lead, solo, !(solo && k > MIN)});
      if (k == d) begin
        if (ref_lead) fb_evt = 1'b1; else ref_evt = 1'b1;
      end
      if (dup && (k == 2 || k == 4) && k < d) begin
        if (ref_lead) ref_evt = 1'b1; else fb_evt = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'b11001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 5'b11001);
    for (int lead = 0; lead < 2; lead++)
      for (int d = 0; d <= 8; d++)
        run_case(lead[0], d, 1'b0);
    run_case(1'b1, 6, 1'b1);
    run_case(1'b0, 6, 1'b1);
    check("R6", 5'b11001);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule